// File: doc/BRIEF.md
# Grouped Level/Edge Interrupt Controller

This block collects 224 interrupt request lines, arranged as seven groups of 32, and reduces each group to one request toward a downstream vectored interrupt controller. Every line can be configured for edge or level triggering and for its active polarity. It also has an enable mask and a pending status bit. The 128 GPIO inputs and two internal events (a timer end-match and a USB cable-detect) reach their group bits through fixed wiring. Some positions are hard-disabled and can never become pending or enabled.

All request inputs pass through a two-flop synchroniser, and edges are found by comparing the newest synchronised sample with the one before it. Software reaches the configuration and status through a 32-bit word-addressed register port, and reads return data combinationally. The port's word address is the byte offset divided by four. Edge-type status bits hold until software writes 1 to them. Level-type status bits follow the input.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset every polarity, status, enable and type register reads zero and all seven `eint` outputs are low.
- R2: Group g (0..6) has its registers at these byte offsets: polarity at 0x80+4g, status at 0xA0+4g, enable at 0xC0+4g and type at 0xE0+4g. Polarity and type read back all 32 written bits. Offsets for a group number of 7 read zero.
- R3: GPIO n sets status in group 6 − (n >> 5), at bit (24 − (n & 24)) | (n & 7). Within each group, the byte order of its 32 GPIOs is therefore reversed.
- R4: Group 0 bit 0 carries the timer end-match event and bit 2 carries the USB detect event. Only those two enable bits of group 0 can be written to 1.
- R5: All bits of groups 1 and 2 are disabled, and so are group 3 bits 4..7 (GPIO 124..127). A disabled bit reads zero in enable and never becomes set in status.
- R6: A bit with type 0 (edge) sets its status on a rising input when its polarity is 1, or on a falling input when its polarity is 0. An edge of the other direction leaves the status unchanged. The status stays set after the input returns.
- R7: Writing 1 to an edge-type status bit clears it. Writing 0 has no effect. An edge that arrives in the same cycle as the clear wins over the clear.
- R8: A bit with type 1 (level) has status 1 exactly while its synchronised input is at the active level (high for polarity 1, low for polarity 0). Writes to its status have no effect.
- R9: `eint[6-g]` is high exactly when group g has at least one bit that is both enabled and pending.
- R10: A change on an input shows in the status register three clock edges later: two synchroniser stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 128 | GPIO interrupt request inputs, asynchronous |
| timer_match | input | 1 | Timer end-match event, asynchronous |
| usb_detect | input | 1 | USB cable detect event, asynchronous |
| bus_word_addr | input | 6 | Register word address (byte offset / 4) |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word_addr`, combinational |
| eint | output | 7 | Group requests; bit 6−g belongs to group g |

## Verification
The assertions assume that the request inputs are already stable by the time they reach the second synchroniser stage. They also assume that a register write lasts exactly one cycle, so a clear strobe can coincide with an edge detection but is never stretched. The stimulus changes every input and bus signal only on falling clock edges, holds each input for at least four cycles, and changes polarity or type only while the affected inputs are steady. Under those conditions no mode change creates a spurious edge.

// File: rtl/grpic_pkg.sv
package grpic_pkg;
  localparam int NGRP  = 7;
  localparam int GW    = 32;
  localparam int NGPIO = 128;
  localparam int AW    = 6;

  typedef enum logic [2:0] {
    K_POL  = 3'd4,
    K_STAT = 3'd5,
    K_EN   = 3'd6,
    K_TYPE = 3'd7
  } reg_kind_e;

  // group that GPIO n lands in
  function automatic int gpio_grp(input int n);
    return (NGRP - 1) - (n >> 5);
  endfunction

  // bit inside that group: byte lane reversed, bit within byte kept
  function automatic int gpio_bit(input int n);
    return (24 - (n & 24)) | (n & 7);
  endfunction

  // hard-wired set of usable bits per group
  function automatic logic [GW-1:0] grp_valid(input int g);
    case (g)
      0:       return 32'h0000_0005;
      1, 2:    return 32'h0000_0000;
      3:       return 32'hFFFF_FF0F;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/grpic_sync.sv
module grpic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= din;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/grpic_route.sv
module grpic_route
  import grpic_pkg::*;
(
  input  logic [NGPIO-1:0]         gpio_in,
  input  logic                     timer_match,
  input  logic                     usb_detect,
  output logic [NGRP-1:0][GW-1:0]  raw
);
  always_comb begin
    raw = '0;
    for (int n = 0; n < NGPIO; n++) begin
      raw[gpio_grp(n)][gpio_bit(n)] = gpio_in[n];
    end
    raw[0][0] = timer_match;
    raw[0][2] = usb_detect;
  end
endmodule

// File: rtl/grpic_group.sv
module grpic_group
  import grpic_pkg::*;
#(
  parameter logic [GW-1:0] VALID = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] cur,
  input  logic [GW-1:0] prev,
  input  logic          wr_pol,
  input  logic          wr_stat,
  input  logic          wr_en,
  input  logic          wr_type,
  input  logic [GW-1:0] wdata,
  output logic [GW-1:0] pol_q,
  output logic [GW-1:0] stat_q,
  output logic [GW-1:0] en_q,
  output logic [GW-1:0] typ_q,
  output logic          irq
);
  // named internal events
  logic [GW-1:0] rise, fall, edge_hit, lvl_act, w1c, clr_only, lvl_bits, stat_nxt;

  assign rise     = cur & ~prev;
  assign fall     = ~cur & prev;
  assign edge_hit = (pol_q & rise) | (~pol_q & fall);
  assign lvl_act  = ~(cur ^ pol_q);
  assign w1c      = wr_stat ? wdata : '0;
  assign clr_only = w1c & ~typ_q & ~edge_hit & VALID;
  assign lvl_bits = typ_q & VALID;
  assign stat_nxt = VALID & ((typ_q & lvl_act) | (~typ_q & ((stat_q & ~w1c) | edge_hit)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      stat_q <= '0;
      en_q   <= '0;
      typ_q  <= '0;
    end else begin
      if (wr_pol)  pol_q <= wdata;
      if (wr_type) typ_q <= wdata;
      if (wr_en)   en_q  <= wdata & VALID;
      stat_q <= stat_nxt;
    end
  end

  assign irq = |(stat_q & en_q);

  // R5: disabled positions never pending or enabled
  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q | en_q) & ~VALID) == '0);

  // R6: a qualifying edge on an edge-type bit is pending next cycle
  a_r6_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    |(edge_hit & ~typ_q & VALID) |=>
      ((stat_q & $past(edge_hit & ~typ_q & VALID)) == $past(edge_hit & ~typ_q & VALID)));

  // R7: a clear with no edge empties the bit
  a_r7_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_only |=> ((stat_q & $past(clr_only)) == '0));

  // R8: level bits mirror the active level
  a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    |lvl_bits |=> ((stat_q & $past(lvl_bits)) == $past(lvl_act & lvl_bits)));

  // R9: a request needs a pending bit
  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NGPIO-1:0]  gpio_in,
  input  logic              timer_match,
  input  logic              usb_detect,
  input  logic [AW-1:0]     bus_word_addr,
  input  logic              bus_we,
  input  logic [GW-1:0]     bus_wdata,
  output logic [GW-1:0]     bus_rdata,
  output logic [NGRP-1:0]   eint
);
  localparam int SW = NGRP * GW;

  logic [NGRP-1:0][GW-1:0] raw, cur, prev;
  logic [NGRP-1:0][GW-1:0] pol_a, stat_a, en_a, typ_a;
  logic [NGRP-1:0]         irq_a;
  logic [2:0]              sel_kind;
  logic [2:0]              sel_grp;
  logic                    grp_ok;

  assign sel_kind = bus_word_addr[5:3];
  assign sel_grp  = bus_word_addr[2:0];
  assign grp_ok   = (int'(sel_grp) < NGRP);

  grpic_route u_route (
    .gpio_in     (gpio_in),
    .timer_match (timer_match),
    .usb_detect  (usb_detect),
    .raw         (raw)
  );

  grpic_sync #(.W(SW)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw),
    .cur  (cur),
    .prev (prev)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = bus_we && grp_ok && (int'(sel_grp) == g);

    grpic_group #(.VALID(grp_valid(g))) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur    (cur[g]),
      .prev   (prev[g]),
      .wr_pol (hit && sel_kind == K_POL),
      .wr_stat(hit && sel_kind == K_STAT),
      .wr_en  (hit && sel_kind == K_EN),
      .wr_type(hit && sel_kind == K_TYPE),
      .wdata  (bus_wdata),
      .pol_q  (pol_a[g]),
      .stat_q (stat_a[g]),
      .en_q   (en_a[g]),
      .typ_q  (typ_a[g]),
      .irq    (irq_a[g])
    );

    // group g drives line NGRP-1-g
    assign eint[NGRP-1-g] = irq_a[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (grp_ok) begin
      case (sel_kind)
        K_POL:   bus_rdata = pol_a[sel_grp];
        K_STAT:  bus_rdata = stat_a[sel_grp];
        K_EN:    bus_rdata = en_a[sel_grp];
        K_TYPE:  bus_rdata = typ_a[sel_grp];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R1: quiet outputs right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (eint == '0));
endmodule

// File: tb/sim_grp_irq_ctrl.sv
module sim_grp_irq_ctrl;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [127:0] gpio_in = '0;
  logic         timer_match = 0;
  logic         usb_detect = 0;
  logic [5:0]   bus_word_addr = '0;
  logic         bus_we = 0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [6:0]   eint;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  grp_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .timer_match(timer_match),
    .usb_detect(usb_detect), .bus_word_addr(bus_word_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eint(eint)
  );

  // {gpio number, expected group, expected bit}
  localparam int VEC [8][3] = '{
    '{0, 6, 24}, '{5, 6, 29}, '{13, 6, 21}, '{31, 6, 7},
    '{40, 5, 16}, '{77, 4, 21}, '{100, 3, 28}, '{123, 3, 3}
  };

  function automatic logic [7:0] a_pol(int g);  return 8'h80 + 8'(4*g); endfunction
  function automatic logic [7:0] a_stat(int g); return 8'hA0 + 8'(4*g); endfunction
  function automatic logic [7:0] a_en(int g);   return 8'hC0 + 8'(4*g); endfunction
  function automatic logic [7:0] a_type(int g); return 8'hE0 + 8'(4*g); endfunction

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_word_addr = off[7:2]; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d);
    bus_word_addr = off[7:2];
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input logic [7:0] off, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(off, d);
    chk(d === exp, req, d, exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    settle(3);
    rst_n = 1;
    settle(1);

    // R1 reset state
    for (int g = 0; g < 7; g++) begin
      chk_reg(a_pol(g), 0, "R1 pol");
      chk_reg(a_stat(g), 0, "R1 stat");
      chk_reg(a_en(g), 0, "R1 en");
      chk_reg(a_type(g), 0, "R1 type");
    end
    chk(eint === 7'd0, "R1 eint", 32'(eint), 0);

    // R2 readback and group-7 hole
    wr(a_pol(4), 32'hA5A5_5A5A);
    chk_reg(a_pol(4), 32'hA5A5_5A5A, "R2 pol readback");
    wr(a_type(2), 32'h1234_8765);
    chk_reg(a_type(2), 32'h1234_8765, "R2 type readback");
    chk_reg(8'h9C, 0, "R2 group7 hole");

    // configure groups 3..6: level, active high, all enabled
    for (int g = 3; g < 7; g++) begin
      wr(a_type(g), 32'hFFFF_FFFF);
      wr(a_pol(g), 32'hFFFF_FFFF);
      wr(a_en(g), 32'hFFFF_FFFF);
    end
    settle(4);

    // R3 / R9 routing table
    for (int i = 0; i < 8; i++) begin
      int n = VEC[i][0];
      int g = VEC[i][1];
      int b = VEC[i][2];
      gpio_in[n] = 1'b1;
      settle(4);
      chk_reg(a_stat(g), 32'h1 << b, "R3 routing");
      chk(eint[6-g] === 1'b1, "R9 eint high", 32'(eint), 32'h1 << (6-g));
      gpio_in[n] = 1'b0;
      settle(4);
      chk_reg(a_stat(g), 0, "R8 level release");
      chk(eint === 7'd0, "R9 eint low", 32'(eint), 0);
    end

    // R4 internal sources on group 0
    wr(a_type(0), 32'hFFFF_FFFF);
    wr(a_pol(0), 32'hFFFF_FFFF);
    wr(a_en(0), 32'hFFFF_FFFF);
    chk_reg(a_en(0), 32'h5, "R4 en mask");
    timer_match = 1;
    settle(4);
    chk_reg(a_stat(0), 32'h1, "R4 timer");
    chk(eint[6] === 1'b1, "R4 eint6", 32'(eint), 32'h40);
    usb_detect = 1;
    settle(4);
    chk_reg(a_stat(0), 32'h5, "R4 usb");
    timer_match = 0; usb_detect = 0;
    settle(4);

    // R5 disabled positions
    wr(a_en(1), 32'hFFFF_FFFF);
    wr(a_en(2), 32'hFFFF_FFFF);
    chk_reg(a_en(1), 0, "R5 g1 en");
    chk_reg(a_en(2), 0, "R5 g2 en");
    chk_reg(a_en(3), 32'hFFFF_FF0F, "R5 g3 en");
    wr(a_type(1), 32'hFFFF_FFFF);
    wr(a_pol(1), 32'h0);
    settle(3);
    chk_reg(a_stat(1), 0, "R5 g1 stat");
    gpio_in[127:124] = 4'hF;
    settle(4);
    chk_reg(a_stat(3), 0, "R5 gpio124-127");
    wr(a_pol(3), 32'h0);
    settle(2);
    chk_reg(a_stat(3), 32'hFFFF_FF0F, "R5 g3 active-low mask");
    wr(a_pol(3), 32'hFFFF_FFFF);
    gpio_in[127:124] = 4'h0;
    settle(4);

    // R6 / R7 edge mode on group 6
    wr(a_en(6), 32'h0);
    wr(a_type(6), 32'h0);
    wr(a_stat(6), 32'hFFFF_FFFF);
    settle(2);
    chk_reg(a_stat(6), 0, "R7 initial clear");
    gpio_in[0] = 1;
    settle(4);
    gpio_in[0] = 0;
    settle(4);
    chk_reg(a_stat(6), 32'h1 << 24, "R6 rising latched");
    wr(a_pol(6), 32'h0);
    gpio_in[5] = 1;
    settle(4);
    chk_reg(a_stat(6), 32'h1 << 24, "R6 rising ignored when falling");
    gpio_in[5] = 0;
    settle(4);
    chk_reg(a_stat(6), (32'h1 << 24) | (32'h1 << 29), "R6 falling latched");
    wr(a_stat(6), 32'h0);
    chk_reg(a_stat(6), (32'h1 << 24) | (32'h1 << 29), "R7 write zero");
    wr(a_en(6), 32'h1 << 29);
    chk(eint[0] === 1'b1, "R9 enabled pending", 32'(eint), 32'h1);
    wr(a_stat(6), 32'h1 << 24);
    chk_reg(a_stat(6), 32'h1 << 29, "R7 w1c");
    wr(a_en(6), 32'h1 << 24);
    chk(eint[0] === 1'b0, "R9 enabled not pending", 32'(eint), 0);

    // R8 level, active low, on group 5
    wr(a_pol(5), 32'h0);
    wr(a_en(5), 32'h0);
    settle(2);
    chk_reg(a_stat(5), 32'hFFFF_FFFF, "R8 active low");
    gpio_in[40] = 1;
    settle(4);
    chk_reg(a_stat(5), 32'hFFFE_FFFF, "R8 inactive bit");
    wr(a_stat(5), 32'hFFFF_FFFF);
    settle(1);
    chk_reg(a_stat(5), 32'hFFFE_FFFF, "R8 w1c ignored");
    wr(a_en(5), 32'h1 << 16);
    chk(eint[1] === 1'b0, "R9 g5 masked", 32'(eint), 0);
    wr(a_en(5), 32'h1);
    chk(eint[1] === 1'b1, "R9 g5 on", 32'(eint), 32'h2);
    gpio_in[40] = 0;

    // R10 latency on group 6 bit 7 (GPIO 31), level high
    wr(a_type(6), 32'hFFFF_FFFF);
    wr(a_pol(6), 32'hFFFF_FFFF);
    settle(4);
    @(negedge clk);
    gpio_in[31] = 1;
    settle(2);
    chk_reg(a_stat(6), 0, "R10 not yet after two edges");
    settle(1);
    chk_reg(a_stat(6), 32'h1 << 7, "R10 after three edges");
    gpio_in[31] = 0;
    settle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule